// File: doc/BRIEF.md
# Shared-Bus Fetch and Data Address Generator

This block produces the memory address for a non-pipelined 16-bit processor in which code and data live in one 64-word memory behind a single address bus. It holds two 6-bit pointers: an instruction pointer and a data pointer. The instruction pointer advances by one on each ordinary step. A jump loads it with a new value in parallel. The data pointer is used only for load and store accesses.

A load or store needs the shared bus for a second cycle. When the decoder raises the load/store select, the data address is captured into the data pointer. For the next cycle, the bus carries the data pointer and the instruction pointer stays where it is. A halt marks where the code region ends and the data region begins. Once a halt is taken, the block freezes the fetch address and raises a sticky halted flag. Only reset clears that flag.

All state changes happen on the rising clock edge. The bus multiplexer is combinational from registered state, so every result appears in the cycle after the edge that sampled the stimulus.

Top module: `prog_addr_unit`

## Requirements
- R1: While reset is asserted and after it is released, the address bus reads 0 and the halted flag reads 0.
- R2: A cycle with only the step input high makes the bus show the instruction pointer plus one after the next rising edge.
- R3: Stepping from address 63 gives address 0. The pointer wraps modulo 64.
- R4: A cycle with jump-load high makes the bus show the jump target after the next rising edge, whether or not step is also high.
- R5: With step, jump-load, load/store select and halt all low, and no data access in progress, the bus keeps its value across an edge.
- R6: A cycle with load/store select high makes the bus carry the data address for the whole of the following cycle. Step and jump-load in that same cycle are ignored.
- R7: The data access lasts one cycle unless select is raised again. The bus then returns to the instruction pointer as it was before the access, and a step requested during the data cycle is ignored.
- R8: A cycle with halt high sets the halted flag (1 = halted) after the next edge. It freezes the bus at the instruction pointer as it was, and it overrides step, jump-load and load/store select in that cycle.
- R9: While halted, step, jump-load, load/store select and halt have no effect: the bus and the halted flag stay constant.
- R10: Asserting reset while halted returns the bus to 0 and the halted flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| step_inc | input | 1 | Advance the instruction pointer by one |
| jump_ld | input | 1 | Load the instruction pointer from jump_tgt |
| jump_tgt | input | 6 | Jump target address |
| ls_sel | input | 1 | Current instruction is a load or store |
| ls_addr | input | 6 | Data address for the load or store |
| halt | input | 1 | Halt decoded |
| mem_addr | output | 6 | Shared memory address |
| halted | output | 1 | Sticky halted flag |

## Verification
Every instruction-pointer update, the capture of the data pointer, the start and end of a data cycle, and the setting of the halted flag each appear exactly one rising edge after the cycle that carries the stimulus. Reset release takes two extra edges because of the internal synchroniser. The bench drives inputs on the falling edge and samples outputs on the following falling edge, which is half a period after the edge that registers the change. Reset tests wait three full cycles after release before checking, and the asynchronous reset value is checked while reset is still held.

// File: rtl/pau_pkg.sv
package pau_pkg;
  typedef enum logic [1:0] {
    IP_HOLD = 2'd0,
    IP_INC  = 2'd1,
    IP_LOAD = 2'd2
  } ip_op_e;
endpackage

// File: rtl/pau_rst_sync.sv
module pau_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/pau_incr.sv
module pau_incr #(
  parameter int W = 6
) (
  input  logic [W-1:0] val_in,
  output logic [W-1:0] val_out
);
  // Half-adder chain with a constant carry-in of one; the final carry is dropped so the count wraps.
  logic [W:0] carry;
  assign carry[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign val_out[i]  = val_in[i] ^ carry[i];
    assign carry[i+1]  = val_in[i] & carry[i];
  end
endmodule

// File: rtl/pau_ctrl.sv
module pau_ctrl
  import pau_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step_inc,
  input  logic   jump_ld,
  input  logic   ls_sel,
  input  logic   halt,
  output ip_op_e ip_op,
  output logic   dp_we,
  output logic   data_phase,
  output logic   halted
);
  logic halted_q, halted_d;
  logic phase_q, phase_d;

  // Next-state logic. Priority: halted > halt > data cycle / select > jump > step.
  always_comb begin
    ip_op    = IP_HOLD;
    dp_we    = 1'b0;
    halted_d = halted_q;
    phase_d  = 1'b0;
    if (halted_q) begin
      ip_op = IP_HOLD;
    end else if (halt) begin
      halted_d = 1'b1;
    end else begin
      if (ls_sel) begin
        dp_we   = 1'b1;
        phase_d = 1'b1;
      end
      if (!ls_sel && !phase_q) begin
        if (jump_ld)       ip_op = IP_LOAD;
        else if (step_inc) ip_op = IP_INC;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      phase_q  <= 1'b0;
    end else begin
      halted_q <= halted_d;
      phase_q  <= phase_d;
    end
  end

  assign halted     = halted_q;
  assign data_phase = phase_q;
endmodule

// File: rtl/pau_iptr.sv
module pau_iptr
  import pau_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ip_op_e       ip_op,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] ip
);
  logic [W-1:0] ip_q, ip_d, ip_plus;
  logic         ip_en;

  pau_incr #(.W(W)) u_incr (
    .val_in  (ip_q),
    .val_out (ip_plus)
  );

  always_comb begin
    ip_en = 1'b0;
    ip_d  = ip_q;
    case (ip_op)
      IP_INC:  begin ip_en = 1'b1; ip_d = ip_plus;  end
      IP_LOAD: begin ip_en = 1'b1; ip_d = load_val; end
      default: begin ip_en = 1'b0; ip_d = ip_q;     end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ip_q <= '0;
    else if (ip_en) ip_q <= ip_d;
  end

  assign ip = ip_q;
endmodule

// File: rtl/pau_dptr.sv
module pau_dptr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] addr_in,
  output logic [W-1:0] dp
);
  logic [W-1:0] dp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  dp_q <= '0;
    else if (we) dp_q <= addr_in;
  end

  assign dp = dp_q;
endmodule

// File: rtl/prog_addr_unit.sv
module prog_addr_unit
  import pau_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_inc,
  input  logic              jump_ld,
  input  logic [ADDR_W-1:0] jump_tgt,
  input  logic              ls_sel,
  input  logic [ADDR_W-1:0] ls_addr,
  input  logic              halt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              halted
);
  logic              rst_n_int;
  ip_op_e            ip_op;
  logic              dp_we;
  logic              data_phase;
  logic [ADDR_W-1:0] ip;
  logic [ADDR_W-1:0] dp;

  pau_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  pau_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .step_inc   (step_inc),
    .jump_ld    (jump_ld),
    .ls_sel     (ls_sel),
    .halt       (halt),
    .ip_op      (ip_op),
    .dp_we      (dp_we),
    .data_phase (data_phase),
    .halted     (halted)
  );

  pau_iptr #(.W(ADDR_W)) u_iptr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .ip_op    (ip_op),
    .load_val (jump_tgt),
    .ip       (ip)
  );

  pau_dptr #(.W(ADDR_W)) u_dptr (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .we      (dp_we),
    .addr_in (ls_addr),
    .dp      (dp)
  );

  assign mem_addr = data_phase ? dp : ip;
endmodule

// File: rtl/prog_addr_unit_chk.sv
module prog_addr_unit_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_inc,
  input logic              jump_ld,
  input logic [ADDR_W-1:0] jump_tgt,
  input logic              ls_sel,
  input logic [ADDR_W-1:0] ls_addr,
  input logic              halt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              halted,
  input logic              data_phase
);
  logic live;
  assign live = !halted && !halt && !data_phase;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !ls_sel && !jump_ld && step_inc) |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

  p_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !ls_sel && jump_ld) |=> mem_addr == $past(jump_tgt));

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !ls_sel && !jump_ld && !step_inc) |=> $stable(mem_addr));

  p_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !halt && ls_sel) |=> mem_addr == $past(ls_addr));

  p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && halt && !data_phase) |=> halted && $stable(mem_addr));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(mem_addr));
endmodule

bind prog_addr_unit prog_addr_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .step_inc   (step_inc),
  .jump_ld    (jump_ld),
  .jump_tgt   (jump_tgt),
  .ls_sel     (ls_sel),
  .ls_addr    (ls_addr),
  .halt       (halt),
  .mem_addr   (mem_addr),
  .halted     (halted),
  .data_phase (data_phase)
);

// File: tb/prog_addr_unit_bench.sv
`timescale 1ns/1ps
module prog_addr_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       step_inc, jump_ld, ls_sel, halt;
  logic [5:0] jump_tgt, ls_addr;
  logic [5:0] mem_addr;
  logic       halted;

  int vectors = 0;
  int misses  = 0;

  always #2.5 clk = ~clk;

  prog_addr_unit u_prog_addr_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_inc (step_inc),
    .jump_ld  (jump_ld),
    .jump_tgt (jump_tgt),
    .ls_sel   (ls_sel),
    .ls_addr  (ls_addr),
    .halt     (halt),
    .mem_addr (mem_addr),
    .halted   (halted)
  );

  task automatic check(string req, logic [5:0] exp_addr, logic exp_halt);
    vectors++;
    if (mem_addr !== exp_addr || halted !== exp_halt) begin
      misses++;
      $display("FAIL %s: mem_addr=%0d halted=%0b expected mem_addr=%0d halted=%0b",
               req, mem_addr, halted, exp_addr, exp_halt);
    end
  endtask

  // Drive one cycle's inputs just after a falling edge; return at the next falling edge.
  task automatic cyc(logic inc, logic jmp, logic [5:0] tgt, logic ls, logic [5:0] la, logic h);
    step_inc = inc; jump_ld = jmp; jump_tgt = tgt;
    ls_sel = ls; ls_addr = la; halt = h;
    @(negedge clk);
    step_inc = 0; jump_ld = 0; ls_sel = 0; halt = 0;
  endtask

  task automatic idle();
    cyc(0, 0, 6'd0, 0, 6'd0, 0);
  endtask

  task automatic do_reset(string req);
    @(negedge clk);
    rst_n = 0;
    #1;
    check(req, 6'd0, 1'b0);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(req, 6'd0, 1'b0);
  endtask

  task automatic t_step();
    cyc(1, 0, 6'd0, 0, 6'd0, 0); check("R2", 6'd1, 0);
    cyc(1, 0, 6'd0, 0, 6'd0, 0); check("R2", 6'd2, 0);
    cyc(1, 0, 6'd0, 0, 6'd0, 0); check("R2", 6'd3, 0);
    idle();                      check("R5", 6'd3, 0);
    idle();                      check("R5", 6'd3, 0);
  endtask

  task automatic t_jump_wrap();
    cyc(1, 1, 6'd40, 0, 6'd0, 0); check("R4", 6'd40, 0);
    cyc(0, 1, 6'd62, 0, 6'd0, 0); check("R4", 6'd62, 0);
    cyc(1, 0, 6'd0, 0, 6'd0, 0);  check("R2", 6'd63, 0);
    cyc(1, 0, 6'd0, 0, 6'd0, 0);  check("R3", 6'd0, 0);
  endtask

  task automatic t_data();
    cyc(0, 1, 6'd5, 0, 6'd0, 0);   check("R4", 6'd5, 0);
    cyc(1, 1, 6'd9, 1, 6'd50, 0);  check("R6", 6'd50, 0);
    cyc(1, 0, 6'd0, 0, 6'd0, 0);   check("R7", 6'd5, 0);
    cyc(1, 0, 6'd0, 0, 6'd0, 0);   check("R2", 6'd6, 0);
    cyc(0, 0, 6'd0, 1, 6'd20, 0);  check("R6", 6'd20, 0);
    cyc(0, 0, 6'd0, 1, 6'd21, 0);  check("R6", 6'd21, 0);
    idle();                        check("R7", 6'd6, 0);
  endtask

  task automatic t_halt();
    cyc(0, 1, 6'd10, 0, 6'd0, 0);  check("R4", 6'd10, 0);
    cyc(1, 1, 6'd30, 1, 6'd44, 1); check("R8", 6'd10, 1);
    cyc(1, 0, 6'd0, 0, 6'd0, 0);   check("R9", 6'd10, 1);
    cyc(0, 1, 6'd17, 0, 6'd0, 0);  check("R9", 6'd10, 1);
    cyc(0, 0, 6'd0, 1, 6'd33, 0);  check("R9", 6'd10, 1);
    idle();                        check("R9", 6'd10, 1);
    do_reset("R10");
  endtask

  task automatic t_halt_in_data();
    cyc(0, 1, 6'd12, 0, 6'd0, 0);  check("R4", 6'd12, 0);
    cyc(0, 0, 6'd0, 1, 6'd30, 0);  check("R6", 6'd30, 0);
    cyc(0, 0, 6'd0, 0, 6'd0, 1);   check("R8", 6'd12, 1);
    idle();                        check("R9", 6'd12, 1);
    do_reset("R10");
  endtask

  initial begin
    #500000;
    misses++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst_n = 0;
    step_inc = 0; jump_ld = 0; ls_sel = 0; halt = 0;
    jump_tgt = 0; ls_addr = 0;
    do_reset("R1");
    t_step();
    t_jump_wrap();
    t_data();
    t_halt();
    t_halt_in_data();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule